// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Dead-Time Insertion

This block converts a two-bit logic command into the high-side and low-side gate enables of one power half-bridge. It works in one of two modes. In the interlocked mode, equal command bits select a conducting side and unequal bits park the bridge with both gates off. Every turn-on is held back by a programmable number of clock cycles, counted from the cycle in which the previous gate was switched off. In the pass-through mode, each command bit drives one gate with no added delay. The caller then owns shoot-through safety.

Two protection qualifiers gate the outputs. A supply-undervoltage flag forces both gates off. A bootstrap-undervoltage flag forces only the high-side gate off. While the qualifiers hold, the sequencer keeps running underneath them. An active-high `awake` input puts the bridge into sleep when low. In sleep both enables drop and a high-impedance indication rises, which tells the pad drivers to float the gate pins. Everything is registered, so every output reacts on the first clock edge that samples its cause.

Top module: `hb_gate_ctrl`

## Requirements
- R1: In interlocked mode (`direct_mode`=0), command `cmd_a`,`cmd_b` = 1,1 selects the high side, 0,0 selects the low side, and 0,1 or 1,0 hold both `hs_en` and `ls_en` at 0.
- R2: In pass-through mode (`direct_mode`=1), `hs_en` equals `cmd_a` and `ls_en` equals `cmd_b` one cycle later, with no dead time. Command 1,1 gives both enables high.
- R3: While `awake` is 0, and after reset, `hs_en`=0, `ls_en`=0 and `hiz`=1 from the next edge on, whatever the command is. With `awake` at 1, `hiz` is 0.
- R4: A command that no longer selects the conducting gate clears that gate's enable at the first edge that samples it.
- R5: In interlocked mode, a selected gate's enable rises exactly D edges after the edge that first samples the new selection. D is `dead_cycles` when it is nonzero.
- R6: When `dead_cycles` is 0, D takes the parameter `DEFAULT_DEAD` (3000 cycles, 12 us at 250 MHz).
- R7: If the selection changes while a countdown is running, the pending turn-on is dropped. The new side then waits its own full D edges from the change.
- R8: `reg_uv`=1 forces both enables to 0 at the next edge. `boot_uv`=1 forces only `hs_en` to 0. The interlock timing continues underneath the qualifiers.
- R9: In interlocked mode, `hs_en` and `ls_en` are never both 1 in the same cycle.
- R10: After leaving sleep or pass-through mode, the first interlocked turn-on waits the full D edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awake | input | 1 | 0 selects sleep with floating gates |
| direct_mode | input | 1 | 1 selects pass-through, 0 selects interlocked |
| cmd_a | input | 1 | Command bit A (high-side bit in pass-through) |
| cmd_b | input | 1 | Command bit B (low-side bit in pass-through) |
| dead_cycles | input | DT_W | Dead time in clock cycles, 0 selects the default |
| reg_uv | input | 1 | Supply undervoltage qualifier |
| boot_uv | input | 1 | Bootstrap undervoltage qualifier |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| hiz | output | 1 | Gate pins float (sleep) |

## Verification
The bench measures the delay to the turn-on edge exactly. A countdown that is off by one in either direction, or that starts from the wrong edge, shows up as a rise one cycle early or late. It changes the selection mid-countdown to catch a design that lets the old count finish and then switches straight to the new side, which would create a dead time shorter than D. It wakes from sleep and returns from pass-through mode straight into a turn-on request, to expose a sequencer that keeps stale state and turns on at once. Random mixes of the qualifiers check that `boot_uv` leaves the low side alone and that a swapped or dropped mask is seen as a wrong enable.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HS   = 2'd1,
        SIDE_LS   = 2'd2
    } side_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // Interlocked decode: equal bits pick a side, unequal bits park the bridge.
    function automatic side_e interlock_target(input logic a, input logic b);
        if (a && b)
            return SIDE_HS;
        if (!a && !b)
            return SIDE_LS;
        return SIDE_NONE;
    endfunction

    function automatic gate_pair_t side_to_gates(input side_e s);
        gate_pair_t g;
        g.hs = (s == SIDE_HS);
        g.ls = (s == SIDE_LS);
        return g;
    endfunction

endpackage

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq
    import hb_gate_pkg::*;
#(
    parameter int DT_W         = 16,
    parameter int DEFAULT_DEAD = 3000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            cmd_a,
    input  logic            cmd_b,
    input  logic [DT_W-1:0] dead_cycles,
    output side_e           side_next
);

    localparam logic [DT_W-1:0] DEF_DEAD = DT_W'(DEFAULT_DEAD);

    side_e           side_q, pend_q, pend_d, tgt;
    logic [DT_W-1:0] cnt_q, cnt_d, dead_eff, reload;

    always_comb begin
        tgt      = interlock_target(cmd_a, cmd_b);
        dead_eff = (dead_cycles == '0) ? DEF_DEAD : dead_cycles;
        reload   = dead_eff - 1'b1;
        side_next = side_q;
        pend_d    = pend_q;
        cnt_d     = cnt_q;
        if (clear || tgt == SIDE_NONE) begin
            side_next = SIDE_NONE;
            pend_d    = SIDE_NONE;
            cnt_d     = '0;
        end else if (tgt == side_q) begin
            pend_d = tgt;
        end else if (tgt != pend_q) begin
            side_next = SIDE_NONE;
            pend_d    = tgt;
            cnt_d     = reload;
        end else if (cnt_q == '0) begin
            side_next = tgt;
        end else begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q <= SIDE_NONE;
            pend_q <= SIDE_NONE;
            cnt_q  <= '0;
        end else begin
            side_q <= side_next;
            pend_q <= pend_d;
            cnt_q  <= cnt_d;
        end
    end

    AST_PROMPT_OFF: assert property (@(posedge clk) disable iff (rst)
        (!clear && interlock_target(cmd_a, cmd_b) == SIDE_NONE) |=> (side_q == SIDE_NONE)); // R4

    AST_CANCEL_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!clear && tgt != SIDE_NONE && tgt != side_q && tgt != pend_q)
        |=> (side_q == SIDE_NONE && cnt_q == $past(reload))); // R7

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (rst)
        clear |=> (side_q == SIDE_NONE && pend_q == SIDE_NONE)); // R10

endmodule

// File: rtl/hb_gate_qualify.sv
module hb_gate_qualify
    import hb_gate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  awake,
    input  logic  direct_mode,
    input  logic  cmd_a,
    input  logic  cmd_b,
    input  side_e side_next,
    input  logic  reg_uv,
    input  logic  boot_uv,
    output logic  hs_en,
    output logic  ls_en,
    output logic  hiz
);

    gate_pair_t want, gate_q;
    logic       hiz_q;

    always_comb begin
        if (direct_mode) begin
            want.hs = cmd_a;
            want.ls = cmd_b;
        end else begin
            want = side_to_gates(side_next);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !awake) begin
            gate_q <= '0;
            hiz_q  <= 1'b1;
        end else begin
            gate_q.hs <= want.hs & ~reg_uv & ~boot_uv;
            gate_q.ls <= want.ls & ~reg_uv;
            hiz_q     <= 1'b0;
        end
    end

    assign hs_en = gate_q.hs;
    assign ls_en = gate_q.ls;
    assign hiz   = hiz_q;

    AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (rst)
        !awake |=> (hiz && !hs_en && !ls_en)); // R3

    AST_SUPPLY_UV: assert property (@(posedge clk) disable iff (rst)
        reg_uv |=> (!hs_en && !ls_en)); // R8

    AST_BOOT_UV: assert property (@(posedge clk) disable iff (rst)
        boot_uv |=> !hs_en); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (direct_mode && awake && !reg_uv && !boot_uv)
        |=> (hs_en == $past(cmd_a) && ls_en == $past(cmd_b))); // R2

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !direct_mode |=> !(hs_en && ls_en)); // R9

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int DT_W         = 16,
    parameter int DEFAULT_DEAD = 3000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            awake,
    input  logic            direct_mode,
    input  logic            cmd_a,
    input  logic            cmd_b,
    input  logic [DT_W-1:0] dead_cycles,
    input  logic            reg_uv,
    input  logic            boot_uv,
    output logic            hs_en,
    output logic            ls_en,
    output logic            hiz
);

    side_e side_next;
    logic  seq_clear;

    assign seq_clear = !awake || direct_mode;

    hb_deadtime_seq #(
        .DT_W         (DT_W),
        .DEFAULT_DEAD (DEFAULT_DEAD)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .clear       (seq_clear),
        .cmd_a       (cmd_a),
        .cmd_b       (cmd_b),
        .dead_cycles (dead_cycles),
        .side_next   (side_next)
    );

    hb_gate_qualify qual_i (
        .clk         (clk),
        .rst         (rst),
        .awake       (awake),
        .direct_mode (direct_mode),
        .cmd_a       (cmd_a),
        .cmd_b       (cmd_b),
        .side_next   (side_next),
        .reg_uv      (reg_uv),
        .boot_uv     (boot_uv),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .hiz         (hiz)
    );

endmodule

// File: tb/hb_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb_top;

    localparam int DT_W    = 16;
    localparam int DEF_DT  = 3000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            awake = 1'b0;
    logic            direct_mode = 1'b0;
    logic            cmd_a = 1'b0;
    logic            cmd_b = 1'b1;
    logic [DT_W-1:0] dead_cycles = 16'd4;
    logic            reg_uv = 1'b0;
    logic            boot_uv = 1'b0;
    logic            hs_en, ls_en, hiz;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    bit    model_on = 1'b0;
    string tag      = "R3";

    always #2 clk = ~clk;

    hb_gate_ctrl #(.DT_W(DT_W), .DEFAULT_DEAD(DEF_DT)) dut_i (
        .clk(clk), .rst(rst), .awake(awake), .direct_mode(direct_mode),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .dead_cycles(dead_cycles),
        .reg_uv(reg_uv), .boot_uv(boot_uv),
        .hs_en(hs_en), .ls_en(ls_en), .hiz(hiz)
    );

    // Reference model computed from the requirements
    logic m_hs, m_ls, m_hiz, prev_dir;
    int   m_tgt, m_age;

    function automatic int want_side(input logic a, input logic b);
        if (a && b) return 1;      // high side, R1
        if (!a && !b) return 2;    // low side, R1
        return 0;
    endfunction

    function automatic int eff_dead(input logic [DT_W-1:0] d);
        return (d == 0) ? DEF_DT : int'(d);   // R6
    endfunction

    always @(posedge clk) begin
        int  t;
        bit  on;
        prev_dir = direct_mode;
        if (rst || !awake) begin
            m_hs = 0; m_ls = 0; m_hiz = 1; m_tgt = 0; m_age = 0;
        end else begin
            m_hiz = 0;
            if (direct_mode) begin
                m_hs = cmd_a & ~reg_uv & ~boot_uv;
                m_ls = cmd_b & ~reg_uv;
                m_tgt = 0; m_age = 0;
            end else begin
                t = want_side(cmd_a, cmd_b);
                if (t != m_tgt) begin
                    m_tgt = t; m_age = 1;
                end else if (m_age < 1000000) begin
                    m_age++;
                end
                on   = (t != 0) && (m_age > eff_dead(dead_cycles));
                m_hs = on && t == 1 && !reg_uv && !boot_uv;
                m_ls = on && t == 2 && !reg_uv;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst && !done) begin
            chk(hs_en == m_hs, tag, "hs_en", hs_en, m_hs);
            chk(ls_en == m_ls, tag, "ls_en", ls_en, m_ls);
            chk(hiz == m_hiz, tag, "hiz", hiz, m_hiz);
            if (!prev_dir)
                chk(!(hs_en && ls_en), "R9", "overlap", hs_en & ls_en, 0);
        end
    end

    task automatic drive(input logic a, input logic b);
        @(negedge clk);
        cmd_a = a; cmd_b = b;
    endtask

    // Drive a command and count negedges until the chosen enable is high.
    task automatic measure(input logic a, input logic b, input bit hs_side, output int n);
        drive(a, b);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(hs_side ? hs_en : ls_en) && n < 10000);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(hs_en == 0 && ls_en == 0, "R3", "reset enables", {hs_en, ls_en}, 0);
        chk(hiz == 1, "R3", "reset hiz", hiz, 1);
        rst = 0; model_on = 1;
        @(negedge clk);
        awake = 1;
        repeat (3) @(negedge clk);

        // R5: rise exactly D edges after sampling edge -> D+1 negedges
        tag = "R5";
        measure(1, 1, 1, n);
        chk(n == 5, "R5", "hs delay", n, 5);
        repeat (3) @(negedge clk);
        // R4: immediate turn-off
        tag = "R4";
        drive(0, 1);
        @(negedge clk);
        chk(hs_en == 0, "R4", "hs off next edge", hs_en, 0);
        // R1: low side via 00
        tag = "R1";
        measure(0, 0, 0, n);
        chk(n == 5 && hs_en == 0, "R1", "ls via 00", n, 5);
        drive(1, 0);
        @(negedge clk);
        chk(!hs_en && !ls_en, "R1", "10 parks", {hs_en, ls_en}, 0);
        // R7: cancel mid-countdown
        tag = "R7";
        drive(1, 1);
        @(negedge clk);
        measure(0, 0, 0, n);
        chk(n == 5, "R7", "restart on change", n, 5);
        drive(0, 1);
        repeat (2) @(negedge clk);

        // R6: default dead time
        tag = "R6";
        dead_cycles = 0;
        measure(1, 1, 1, n);
        chk(n == DEF_DT + 1, "R6", "default delay", n, DEF_DT + 1);
        drive(0, 1);
        @(negedge clk);
        dead_cycles = 3;

        // R10: sleep then immediate request
        tag = "R10";
        awake = 0;
        drive(1, 1);
        @(negedge clk);
        chk(hiz == 1 && !hs_en, "R3", "sleep floats", hiz, 1);
        awake = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_en && n < 100);
        chk(n == 4, "R10", "wake delay", n, 4);

        // R1/R5/R7 random interlocked traffic
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1));
            repeat ($urandom_range(0, 7)) @(negedge clk);
        end
        // R8 random qualifiers
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1));
            reg_uv  = ($urandom_range(0, 5) == 0);
            boot_uv = ($urandom_range(0, 3) == 0);
            repeat ($urandom_range(0, 6)) @(negedge clk);
        end
        // R2 pass-through
        tag = "R2";
        direct_mode = 1;
        for (int i = 0; i < 300; i++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1));
            reg_uv  = ($urandom_range(0, 7) == 0);
            boot_uv = ($urandom_range(0, 7) == 0);
        end
        reg_uv = 0; boot_uv = 0;
        drive(1, 1);
        @(negedge clk);
        chk(hs_en && ls_en, "R2", "both on", {hs_en, ls_en}, 3);
        // R10 return to interlocked
        tag = "R10";
        direct_mode = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!hs_en && n < 100);
        chk(n == 4, "R10", "mode return delay", n, 4);
        // R3 mixed sleep, modes, qualifiers
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1));
            awake       = ($urandom_range(0, 9) != 0);
            direct_mode = ($urandom_range(0, 7) == 0);
            reg_uv      = ($urandom_range(0, 9) == 0);
            boot_uv     = ($urandom_range(0, 9) == 0);
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end
        @(negedge clk);
        summary();
    end

endmodule